// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs the conversion schedule of an analog-to-digital converter. A bank of control entries, each naming one input channel, is supplied as a flat configuration vector. When the block is enabled and sees a trigger pulse, it starts a run. Each conversion asks an abstract converter core for a sample over a request/done handshake, using the channel of the current entry. Each returned 16-bit result is written to a result store.

There are four modes. Single converts one entry once. Sequence walks from a first entry to a last entry, one conversion per trigger. Repeat single converts one entry again and again. Repeat sequence loops over a range of entries. In the repeat modes, clearing the enable input ends the run once the conversion in flight has finished.

Results are placed in consecutive store slots, counted from slot 0 at the start of every run. This slot count is kept apart from the control-entry index: the slot advances with every result, whichever entry produced it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `conv_req`, `res_we` and `seq_done` are 0 and `res_idx` is 0.
- R2: From idle, a cycle with `enable` and `trigger` both high starts a run, and `conv_req` is high in the next cycle. A trigger while `enable` is low does nothing. `conv_req` stays high until the cycle in which `conv_done` is seen.
- R3: During a request, `conv_chan` equals the channel field of the current entry. Entry k occupies bits `chan_cfg[k*CH_W +: CH_W]`.
- R4: Mode 2'b00 (single) converts entry `start_idx` once. The block then returns to idle, and `seq_done` is high for exactly the one cycle after the cycle holding `conv_done`.
- R5: Mode 2'b01 (sequence) converts entries `start_idx` through `end_idx` in ascending order, one conversion per trigger. `seq_done` is pulsed only after the last entry.
- R6: In a sequence mode, an `end_idx` below `start_idx` makes the run use the start entry alone.
- R7: Mode 2'b10 (repeat single) converts entry `start_idx` on every trigger for as long as `enable` stays high, with no `seq_done` between conversions.
- R8: Mode 2'b11 (repeat sequence) wraps from the end entry back to the start entry and keeps going while `enable` is high.
- R9: If `enable` is low in the cycle of `conv_done`, that result is still written. The block then goes idle and pulses `seq_done`, and it issues no further requests.
- R10: `res_we` is high in exactly the cycle of `conv_done` during a request, with `res_data` equal to `conv_data`. `res_idx` is 0 for the first result of each run and rises by one per result, whatever the entry index.
- R11: `res_idx` wraps to 0 after slot RES_DEPTH-1. The default RES_DEPTH is 16.
- R12: `mode`, `start_idx` and `end_idx` are captured when a run starts. Changing them during the run does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows runs to start and continue |
| trigger | input | 1 | Pulse that starts the next conversion |
| mode | input | 2 | 00 single, 01 sequence, 10 repeat single, 11 repeat sequence |
| start_idx | input | 3 | First (or only) control entry |
| end_idx | input | 3 | Last control entry in sequence modes |
| chan_cfg | input | 40 | Channel fields of all entries, entry k at bits k*5 +: 5 |
| conv_req | output | 1 | Conversion request to the converter core |
| conv_chan | output | 5 | Channel for the requested conversion |
| conv_done | input | 1 | Converter core finished; result valid |
| conv_data | input | 16 | Conversion result |
| res_we | output | 1 | Result store write strobe |
| res_idx | output | 4 | Result store slot |
| res_data | output | 16 | Result store write data |
| busy | output | 1 | A run is in progress |
| seq_done | output | 1 | One-cycle pulse when a run ends |

## Verification
A wrong entry index shows up at once as a wrong `conv_chan` in the very next request cycle, so every conversion compares the channel against the configured field. A slot counter that has drifted, or that failed to clear, shows up as a wrong `res_idx` in the same cycle as `conv_done`. A state machine fault shows up either as a missing or extra `seq_done` in the cycle after the final result, or as a request that appears when idle. Each of these is therefore visible within one cycle of the conversion that exposes it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE     = 2'b00,
    MODE_SEQ        = 2'b01,
    MODE_RPT_SINGLE = 2'b10,
    MODE_RPT_SEQ    = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_CONV = 2'b10
  } seq_state_e;

  function automatic logic mode_repeats(input conv_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_walks(input conv_mode_e m);
    return m[0];
  endfunction

  // Final entry of a run: the start entry itself unless a valid ascending range.
  function automatic logic [7:0] final_entry(input conv_mode_e m,
                                             input logic [7:0] first,
                                             input logic [7:0] last);
    if (mode_walks(m) && (last >= first))
      return last;
    return first;
  endfunction

endpackage

// File: rtl/adc_seq_entry_ctr.sv
module adc_seq_entry_ctr
  import adc_seq_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  conv_mode_e    mode_in,
  input  logic [EW-1:0] first_in,
  input  logic [EW-1:0] last_in,
  output logic [EW-1:0] cur,
  output logic [EW-1:0] first,
  output logic [EW-1:0] last,
  output logic          at_last
);

  logic [7:0] last_wide;

  always_comb begin
    last_wide = final_entry(mode_in, 8'(first_in), 8'(last_in));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur   <= '0;
      first <= '0;
      last  <= '0;
    end else if (load) begin
      cur   <= first_in;
      first <= first_in;
      last  <= last_wide[EW-1:0];
    end else if (advance) begin
      cur <= (cur == last) ? first : cur + EW'(1);
    end
  end

  assign at_last = (cur == last);

endmodule

// File: rtl/adc_seq_chan_sel.sv
module adc_seq_chan_sel #(
  parameter int N_ENTRIES = 8,
  parameter int CH_W      = 5,
  localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES*CH_W-1:0] cfg,
  input  logic [EW-1:0]             sel,
  output logic [CH_W-1:0]           chan
);

  logic [CH_W-1:0] fields [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_field
    assign fields[g] = cfg[g*CH_W +: CH_W];
  end

  always_comb begin
    chan = '0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      if (sel == EW'(k)) chan = fields[k];
    end
  end

endmodule

// File: rtl/adc_seq_res_ptr.sv
module adc_seq_res_ptr #(
  parameter int RES_DEPTH = 16,
  localparam int RAW = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           step,
  output logic [RAW-1:0] idx
);

  function automatic logic [RAW-1:0] next_slot(input logic [RAW-1:0] s);
    return (int'(s) == RES_DEPTH - 1) ? '0 : s + RAW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= next_slot(idx);
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       trigger,
  input  conv_mode_e mode_in,
  input  logic       conv_done,
  input  logic       at_last,
  output logic       start_evt,
  output logic       conv_evt,
  output logic       step_evt,
  output logic       end_evt,
  output logic       in_conv,
  output logic       running,
  output logic       done_pulse
);

  seq_state_e state, state_nx;
  conv_mode_e mode_q;

  always_comb begin
    state_nx  = state;
    start_evt = 1'b0;
    conv_evt  = 1'b0;
    step_evt  = 1'b0;
    end_evt   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable && trigger) begin
          start_evt = 1'b1;
          state_nx  = ST_CONV;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          conv_evt = 1'b1;
          if (!enable || (at_last && !mode_repeats(mode_q))) begin
            end_evt  = 1'b1;
            state_nx = ST_IDLE;
          end else begin
            step_evt = 1'b1;
            state_nx = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!enable) begin
          end_evt  = 1'b1;
          state_nx = ST_IDLE;
        end else if (trigger) begin
          state_nx = ST_CONV;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= MODE_SINGLE;
      done_pulse <= 1'b0;
    end else begin
      state      <= state_nx;
      done_pulse <= end_evt;
      if (start_evt) mode_q <= mode_in;
    end
  end

  assign in_conv = (state == ST_CONV);
  assign running = (state != ST_IDLE);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int CH_W      = 5,
  parameter int RES_W     = 16,
  parameter int RES_DEPTH = 16,
  localparam int EW  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int RAW = (RES_DEPTH > 1) ? $clog2(RES_DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic                      trigger,
  input  logic [1:0]                mode,
  input  logic [EW-1:0]             start_idx,
  input  logic [EW-1:0]             end_idx,
  input  logic [N_ENTRIES*CH_W-1:0] chan_cfg,
  output logic                      conv_req,
  output logic [CH_W-1:0]           conv_chan,
  input  logic                      conv_done,
  input  logic [RES_W-1:0]          conv_data,
  output logic                      res_we,
  output logic [RAW-1:0]            res_idx,
  output logic [RES_W-1:0]          res_data,
  output logic                      busy,
  output logic                      seq_done
);

  // Named internal events, visible to the bound checker.
  logic          start_evt, conv_evt, step_evt, end_evt, in_conv;
  logic [EW-1:0] cur_entry, first_entry, last_entry;
  logic          at_last;
  conv_mode_e    mode_e;

  assign mode_e = conv_mode_e'(mode);

  adc_seq_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .trigger    (trigger),
    .mode_in    (mode_e),
    .conv_done  (conv_done),
    .at_last    (at_last),
    .start_evt  (start_evt),
    .conv_evt   (conv_evt),
    .step_evt   (step_evt),
    .end_evt    (end_evt),
    .in_conv    (in_conv),
    .running    (busy),
    .done_pulse (seq_done)
  );

  adc_seq_entry_ctr #(.N_ENTRIES(N_ENTRIES)) i_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_evt),
    .advance  (step_evt),
    .mode_in  (mode_e),
    .first_in (start_idx),
    .last_in  (end_idx),
    .cur      (cur_entry),
    .first    (first_entry),
    .last     (last_entry),
    .at_last  (at_last)
  );

  adc_seq_chan_sel #(.N_ENTRIES(N_ENTRIES), .CH_W(CH_W)) i_chan (
    .cfg  (chan_cfg),
    .sel  (cur_entry),
    .chan (conv_chan)
  );

  adc_seq_res_ptr #(.RES_DEPTH(RES_DEPTH)) i_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_evt),
    .step  (conv_evt),
    .idx   (res_idx)
  );

  assign conv_req = in_conv;
  assign res_we   = conv_evt;
  assign res_data = conv_data;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int EW  = 3,
  parameter int RAW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           conv_req,
  input logic           conv_done,
  input logic           res_we,
  input logic [RAW-1:0] res_idx,
  input logic           busy,
  input logic           seq_done,
  input logic           start_evt,
  input logic [EW-1:0]  cur_entry,
  input logic [EW-1:0]  first_entry,
  input logic [EW-1:0]  last_entry
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !conv_req) else $error("idle request");  // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done && enable) |=> conv_req) else $error("request dropped");  // R2

  AST_WE_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (conv_req && conv_done)) else $error("stray write");  // R10

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (res_idx == $past(res_idx) + RAW'(1))) else $error("slot step");  // R11

  AST_RUN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (res_idx == '0)) else $error("slot not cleared");  // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done) else $error("long done");  // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy) else $error("done while busy");  // R9

  AST_ENTRY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_entry >= first_entry && cur_entry <= last_entry)) else $error("entry range");  // R5

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.EW(EW), .RAW(RAW)) i_adc_seq_ctrl_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .conv_req    (conv_req),
  .conv_done   (conv_done),
  .res_we      (res_we),
  .res_idx     (res_idx),
  .busy        (busy),
  .seq_done    (seq_done),
  .start_evt   (start_evt),
  .cur_entry   (cur_entry),
  .first_entry (first_entry),
  .last_entry  (last_entry)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        trigger = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  start_idx = '0;
  logic [2:0]  end_idx = '0;
  logic [39:0] chan_cfg;
  logic        conv_req;
  logic [4:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [15:0] conv_data = '0;
  logic        res_we;
  logic [3:0]  res_idx;
  logic [15:0] res_data;
  logic        busy;
  logic        seq_done;

  int checks = 0;
  int errors = 0;
  int dval = 16'hA000;

  always #4 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trigger(trigger), .mode(mode),
    .start_idx(start_idx), .end_idx(end_idx), .chan_cfg(chan_cfg),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .res_we(res_we), .res_idx(res_idx), .res_data(res_data),
    .busy(busy), .seq_done(seq_done)
  );

  function automatic int ch(input int k);
    return (k * 7 + 3) % 32;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // One triggered conversion of entry exp_entry into slot exp_slot.
  task automatic convert(input int exp_entry, input int exp_slot, input bit exp_end,
                         input bit drop_en, input string rq);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0; #1;
    chk({rq, " R2 request"}, int'(conv_req), 1);
    chk({rq, " R3 channel"}, int'(conv_chan), ch(exp_entry));
    @(negedge clk); #1;
    chk({rq, " R2 request held"}, int'(conv_req), 1);
    chk({rq, " R10 no early write"}, int'(res_we), 0);
    if (drop_en) enable = 1'b0;
    conv_done = 1'b1; conv_data = 16'(dval); #1;
    chk({rq, " R10 write strobe"}, int'(res_we), 1);
    chk({rq, " R10 slot"}, int'(res_idx), exp_slot);
    chk({rq, " R10 data"}, int'(res_data), dval);
    @(negedge clk); conv_done = 1'b0; #1;
    chk({rq, " seq_done"}, int'(seq_done), int'(exp_end));
    chk({rq, " busy"}, int'(busy), int'(!exp_end));
    chk({rq, " no request after done"}, int'(conv_req), 0);
    dval++;
    if (exp_end) begin
      @(negedge clk); #1;
      chk({rq, " R4 done one cycle"}, int'(seq_done), 0);
    end
  endtask

  task automatic idle_trigger(input string rq);
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0; #1;
    chk({rq, " no request"}, int'(conv_req), 0);
    chk({rq, " not busy"}, int'(busy), 0);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 conv_req", int'(conv_req), 0);
    chk("R1 res_we", int'(res_we), 0);
    chk("R1 seq_done", int'(seq_done), 0);
    chk("R1 res_idx", int'(res_idx), 0);
  endtask

  task automatic t_disabled;
    enable = 1'b0; mode = 2'b01; start_idx = 3'd0; end_idx = 3'd3;
    idle_trigger("R2 disabled trigger");
  endtask

  task automatic t_single;
    enable = 1'b1; mode = 2'b00; start_idx = 3'd5; end_idx = 3'd7;
    convert(5, 0, 1'b1, 1'b0, "R4 single");
    enable = 1'b0;
  endtask

  task automatic t_sequence;
    enable = 1'b1; mode = 2'b01; start_idx = 3'd2; end_idx = 3'd5;
    convert(2, 0, 1'b0, 1'b0, "R5 seq e2");
    mode = 2'b00; start_idx = 3'd7; end_idx = 3'd0;  // R12: must not affect the run
    convert(3, 1, 1'b0, 1'b0, "R12 seq e3");
    convert(4, 2, 1'b0, 1'b0, "R5 seq e4");
    convert(5, 3, 1'b1, 1'b0, "R5 seq e5 last");
    enable = 1'b0;
  endtask

  task automatic t_backward;
    enable = 1'b1; mode = 2'b01; start_idx = 3'd6; end_idx = 3'd2;
    convert(6, 0, 1'b1, 1'b0, "R6 reversed range");
    enable = 1'b0;
  endtask

  task automatic t_repeat_single;
    enable = 1'b1; mode = 2'b10; start_idx = 3'd1; end_idx = 3'd4;
    convert(1, 0, 1'b0, 1'b0, "R7 rpt single 0");
    convert(1, 1, 1'b0, 1'b0, "R7 rpt single 1");
    convert(1, 2, 1'b1, 1'b1, "R9 rpt single stop");
    idle_trigger("R9 after stop");
  endtask

  task automatic t_repeat_seq;
    enable = 1'b1; mode = 2'b11; start_idx = 3'd6; end_idx = 3'd7;
    convert(6, 0, 1'b0, 1'b0, "R8 rpt seq a");
    convert(7, 1, 1'b0, 1'b0, "R8 rpt seq b");
    convert(6, 2, 1'b0, 1'b0, "R8 rpt seq wrap");
    convert(7, 3, 1'b0, 1'b0, "R8 rpt seq d");
    convert(6, 4, 1'b1, 1'b1, "R9 rpt seq stop");
    idle_trigger("R9 rpt seq after stop");
  endtask

  task automatic t_slot_wrap;
    enable = 1'b1; mode = 2'b11; start_idx = 3'd0; end_idx = 3'd7;
    for (int n = 0; n < 18; n++) begin
      convert(n % 8, n % 16, n == 17, n == 17, "R11 slot wrap");
    end
  endtask

  initial begin
    for (int k = 0; k < 8; k++) chan_cfg[k*5 +: 5] = 5'(ch(k));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_single();
    t_sequence();
    t_backward();
    t_repeat_single();
    t_repeat_seq();
    t_slot_wrap();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule